// File: doc/BRIEF.md
# Shared-Buffer Multi-Queue

This block keeps several independent FIFO packet queues, one per attached node, inside a single shared storage array. Buffer space is pooled: any queue may grow into any unused slot. Each queue is a linked list of slots, and each slot holds a descriptor and a pointer to the next slot. The unused slots form a second linked list, the free list, which lives in the same storage. Removing an entry from any queue hands its slot straight back to that list, so the storage never fragments.

Each accepted operation needs one storage read and one storage write, and these take two clock cycles. While an operation is in flight, `ready` is low. Every queue owns one allocated but empty slot at its tail. An enqueue writes the descriptor into that slot and links in a fresh slot as the new tail, all in a single write. For this reason, DEPTH minus NQ descriptors fit at once. After reset, the block spends DEPTH cycles chaining every slot before it accepts traffic.

Top module: `shared_multi_queue`

## Requirements
- R1: For DEPTH cycles after reset is released, `ready` is low while the storage is chained. From the DEPTH-th negedge after release, `ready` is high, every bit of `q_empty` is 1 and `full` is 0.
- R2: Descriptors dequeued from a queue come out in the order they were enqueued to that queue. Traffic on other queues has no effect on that order.
- R3: An enqueue is accepted when `ready` is high, `enq_valid` is high, `deq_valid` is low, `enq_qid` < NQ and `full` is low. `ready` is then low for exactly one cycle.
- R4: A dequeue is accepted at edge E0 when `ready` is high, `deq_valid` is high, `deq_qid` < NQ and that queue is not empty. At edge E1, `deq_vld` rises for one cycle with the head descriptor on `deq_data`, and `ready` is low between E0 and E1.
- R5: `full` is high exactly when DEPTH minus NQ descriptors are stored, whatever the mix of queues. An enqueue while `full` is high is refused: no queue content changes and `ready` stays high.
- R6: A dequeue request on an empty queue, or with `deq_qid` >= NQ, changes no state. `deq_err` is high for one cycle after the edge that saw it, `deq_vld` stays low and `ready` stays high.
- R7: When `enq_valid` and `deq_valid` are both high, only the dequeue is considered and the enqueue has no effect.
- R8: An enqueue with `enq_qid` >= NQ has no effect on any queue.
- R9: `q_empty[q]` is 1 exactly when queue q holds no descriptor. At all times, free slots plus stored descriptors plus NQ equals DEPTH.
- R10: Slots released by dequeues are reused. After the buffer has been filled and drained, it can be filled again to full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enq_valid | input | 1 | Enqueue request |
| enq_qid | input | QW | Target queue of the enqueue |
| enq_data | input | DW | Descriptor to store |
| deq_valid | input | 1 | Dequeue request |
| deq_qid | input | QW | Queue to dequeue from |
| ready | output | 1 | Block can take a request this cycle |
| deq_vld | output | 1 | `deq_data` holds a dequeued descriptor |
| deq_data | output | DW | Dequeued descriptor |
| deq_err | output | 1 | Pulse for a dequeue on an empty or invalid queue |
| q_empty | output | NQ | Per-queue empty flags |
| full | output | 1 | No free slot left; enqueues are refused |

## Verification
The assertions check on every cycle that slots are conserved between the free list and the queues, and that `full` matches the stored total. They also check the busy window after an accepted request, the error pulse timing, and that a refused enqueue leaves the block full and idle. Descriptor order, the survival of each queue's contents under interleaved traffic and the reuse of freed slots depend on the data, so only the bench's scenarios show them. The bench runs them against per-queue reference FIFOs with fills to capacity, drains and long random mixes that include invalid queue numbers.

// File: rtl/shared_multi_queue.sv
module shared_multi_queue #(
  parameter int NQ = 7,
  parameter int DEPTH = 128,
  parameter int DW = 36,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enq_valid,
  input  logic [QW-1:0] enq_qid,
  input  logic [DW-1:0] enq_data,
  input  logic          deq_valid,
  input  logic [QW-1:0] deq_qid,
  output logic          ready,
  output logic          deq_vld,
  output logic [DW-1:0] deq_data,
  output logic          deq_err,
  output logic [NQ-1:0] q_empty,
  output logic          full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int WW = DW + AW;

  logic [WW-1:0] mem [DEPTH];
  logic [WW-1:0] rd_q;
  logic [NQ-1:0][AW-1:0] head, tail;
  logic [NQ-1:0][CW-1:0] cnt;
  logic [AW-1:0] free_head, init_idx, rd_addr, wr_addr;
  logic [CW-1:0] free_cnt;
  logic init, busy, op_deq;
  logic [QW-1:0] op_q;
  logic [DW-1:0] op_data;
  logic enq_in_range, deq_in_range, acc_enq, acc_deq;
  logic [WW-1:0] wr_word;

  assign enq_in_range = {1'b0, enq_qid} < (QW+1)'(NQ);
  assign deq_in_range = {1'b0, deq_qid} < (QW+1)'(NQ);
  assign ready   = !init && !busy;
  assign full    = free_cnt == '0;
  assign acc_enq = ready && enq_valid && !deq_valid && enq_in_range && !full;
  assign acc_deq = ready && deq_valid && deq_in_range && cnt[deq_qid] != '0;
  assign rd_addr = acc_deq ? head[deq_qid] : free_head;
  assign wr_addr = op_deq ? head[op_q] : tail[op_q];
  assign wr_word = op_deq ? {rd_q[WW-1:AW], free_head} : {op_data, free_head};

  for (genvar g = 0; g < NQ; g++) begin : g_empty
    assign q_empty[g] = cnt[g] == '0;
  end

  always_ff @(posedge clk) begin
    if (init) mem[init_idx] <= {{DW{1'b0}}, init_idx + AW'(1)};
    else if (busy) mem[wr_addr] <= wr_word;
    if (acc_enq || acc_deq) rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      init      <= 1'b1;
      init_idx  <= '0;
      busy      <= 1'b0;
      op_deq    <= 1'b0;
      op_q      <= '0;
      op_data   <= '0;
      free_head <= AW'(NQ);
      free_cnt  <= CW'(DEPTH - NQ);
      deq_vld   <= 1'b0;
      deq_err   <= 1'b0;
      deq_data  <= '0;
      for (int q = 0; q < NQ; q++) begin
        head[q] <= AW'(q);
        tail[q] <= AW'(q);
        cnt[q]  <= '0;
      end
    end else begin
      deq_vld <= 1'b0;
      deq_err <= 1'b0;
      if (init) begin
        init_idx <= init_idx + AW'(1);
        if (init_idx == AW'(DEPTH - 1)) init <= 1'b0;
      end else if (busy) begin
        busy <= 1'b0;
        if (op_deq) begin
          head[op_q] <= rd_q[AW-1:0];
          free_head  <= head[op_q];
          free_cnt   <= free_cnt + CW'(1);
          cnt[op_q]  <= cnt[op_q] - CW'(1);
          deq_vld    <= 1'b1;
          deq_data   <= rd_q[WW-1:AW];
        end else begin
          tail[op_q] <= free_head;
          free_head  <= rd_q[AW-1:0];
          free_cnt   <= free_cnt - CW'(1);
          cnt[op_q]  <= cnt[op_q] + CW'(1);
        end
      end else if (acc_enq || acc_deq) begin
        busy    <= 1'b1;
        op_deq  <= acc_deq;
        op_q    <= acc_deq ? deq_qid : enq_qid;
        op_data <= enq_data;
      end else if (ready && deq_valid) begin
        deq_err <= 1'b1;
      end
    end
  end
endmodule

module smq_checker #(
  parameter int NQ = 7,
  parameter int DEPTH = 128,
  parameter int QW = 3,
  parameter int CW = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  ready,
  input logic                  enq_valid,
  input logic [QW-1:0]         enq_qid,
  input logic                  deq_valid,
  input logic [QW-1:0]         deq_qid,
  input logic [NQ-1:0]         q_empty,
  input logic                  full,
  input logic                  deq_vld,
  input logic                  deq_err,
  input logic [CW-1:0]         free_cnt,
  input logic [NQ-1:0][CW-1:0] cnt
);
  int total;
  logic enq_ok, deq_bad;
  always_comb begin
    total = 0;
    for (int q = 0; q < NQ; q++) total += int'(cnt[q]);
  end
  assign enq_ok  = ready && enq_valid && !deq_valid && ({1'b0, enq_qid} < (QW+1)'(NQ)) && !full;
  assign deq_bad = ready && deq_valid &&
                   (({1'b0, deq_qid} >= (QW+1)'(NQ)) || q_empty[deq_qid]);

  a_r9_conserve: assert property (@(posedge clk) disable iff (rst)
    int'(free_cnt) + total + NQ == DEPTH);
  a_r5_full_total: assert property (@(posedge clk) disable iff (rst)
    full |-> total == DEPTH - NQ);
  a_r3_busy_after_enq: assert property (@(posedge clk) disable iff (rst)
    enq_ok |=> !ready);
  a_r5_refuse_when_full: assert property (@(posedge clk) disable iff (rst)
    (ready && enq_valid && !deq_valid && full) |=> (ready && full && $stable(cnt)));
  a_r6_err_pulse: assert property (@(posedge clk) disable iff (rst)
    deq_bad |=> (deq_err && ready && !deq_vld));
  a_r4_vld_after_busy: assert property (@(posedge clk) disable iff (rst)
    deq_vld |-> $past(!ready));
  a_r4_vld_err_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(deq_vld && deq_err));
endmodule

bind shared_multi_queue smq_checker #(.NQ(NQ), .DEPTH(DEPTH), .QW(QW), .CW(CW)) chk_i (
  .clk(clk), .rst(rst), .ready(ready), .enq_valid(enq_valid), .enq_qid(enq_qid),
  .deq_valid(deq_valid), .deq_qid(deq_qid), .q_empty(q_empty), .full(full),
  .deq_vld(deq_vld), .deq_err(deq_err), .free_cnt(free_cnt), .cnt(cnt)
);

// File: tb/shared_multi_queue_tb.sv
module shared_multi_queue_tb_top;
  localparam int NQ = 7;
  localparam int DEPTH = 128;
  localparam int DW = 36;
  localparam int QW = 3;
  localparam int CAP = DEPTH - NQ;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enq_valid = 1'b0, deq_valid = 1'b0;
  logic [QW-1:0] enq_qid = '0, deq_qid = '0;
  logic [DW-1:0] enq_data = '0;
  logic ready, deq_vld, deq_err, full;
  logic [DW-1:0] deq_data;
  logic [NQ-1:0] q_empty;

  always #2 clk = ~clk;

  shared_multi_queue #(.NQ(NQ), .DEPTH(DEPTH), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_qid(enq_qid), .enq_data(enq_data),
    .deq_valid(deq_valid), .deq_qid(deq_qid), .ready(ready), .deq_vld(deq_vld),
    .deq_data(deq_data), .deq_err(deq_err), .q_empty(q_empty), .full(full)
  );

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [DW-1:0] rq [NQ][DEPTH];
  int rh [NQ];
  int rc [NQ];

  function automatic int total();
    int t = 0;
    for (int q = 0; q < NQ; q++) t += rc[q];
    return t;
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int q = 0; q < NQ; q++) begin rh[q] = 0; rc[q] = 0; end
  endtask

  task automatic check_flags();
    for (int q = 0; q < NQ; q++) chk("R9", "q_empty", 64'(q_empty[q]), 64'(rc[q] == 0));
    chk("R5", "full", 64'(full), 64'(total() == CAP));
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!ready) @(negedge clk);
  endtask

  task automatic do_reset();
    int n = 0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    do begin
      @(negedge clk);
      n++;
      if (n == 1) chk("R1", "ready low during init", 64'(ready), 64'(0));
    end while (!ready && n < 1000);
    chk("R1", "init cycles", 64'(n), 64'(DEPTH));
    chk("R1", "all empty", 64'(q_empty), 64'({NQ{1'b1}}));
    chk("R1", "full low", 64'(full), 64'(0));
  endtask

  task automatic do_enq(int q, logic [DW-1:0] d);
    bit take;
    wait_ready();
    take = (q < NQ) && (total() < CAP);
    enq_valid = 1'b1; enq_qid = QW'(q); enq_data = d;
    @(negedge clk);
    enq_valid = 1'b0;
    if (take) begin
      chk("R3", "ready low after enqueue", 64'(ready), 64'(0));
      rq[q][(rh[q] + rc[q]) % DEPTH] = d;
      rc[q]++;
    end else if (q >= NQ) begin
      chk("R8", "ready after bad-qid enqueue", 64'(ready), 64'(1));
    end else begin
      chk("R5", "ready after refused enqueue", 64'(ready), 64'(1));
    end
    while (!ready) @(negedge clk);
    check_flags();
  endtask

  task automatic do_deq(int q, bit with_enq);
    bit bad;
    wait_ready();
    bad = (q >= NQ) || (rc[q] == 0);
    deq_valid = 1'b1; deq_qid = QW'(q);
    if (with_enq) begin enq_valid = 1'b1; enq_qid = QW'((q + 1) % NQ); enq_data = '1; end
    @(negedge clk);
    deq_valid = 1'b0; enq_valid = 1'b0;
    chk("R6", "deq_err", 64'(deq_err), 64'(bad));
    chk(bad ? "R6" : "R4", "ready after dequeue request", 64'(ready), 64'(bad));
    @(negedge clk);
    chk(bad ? "R6" : "R4", "deq_vld", 64'(deq_vld), 64'(!bad));
    if (!bad) begin
      chk("R2", "dequeued descriptor", 64'(deq_data), 64'(rq[q][rh[q]]));
      rh[q] = (rh[q] + 1) % DEPTH;
      rc[q]--;
    end
    check_flags();
  endtask

  function automatic logic [DW-1:0] rnd_data();
    return {4'($urandom()), 32'($urandom())};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(7));
    do_reset();

    // R2: order within one queue, interleaved with another queue
    do_enq(0, 36'h1); do_enq(3, 36'hA); do_enq(0, 36'h2); do_enq(0, 36'h3);
    do_deq(0, 0); do_deq(3, 0); do_deq(0, 0); do_deq(0, 0);

    // R6: empty and out-of-range dequeues
    do_deq(0, 0); do_deq(NQ, 0);

    // R8: enqueue to out-of-range queue leaves every queue empty
    do_enq(NQ, 36'hBAD);
    chk("R8", "all empty after bad enqueue", 64'(q_empty), 64'({NQ{1'b1}}));

    // R7: simultaneous requests, only dequeue takes effect
    do_enq(2, 36'h55);
    do_deq(2, 1);
    chk("R7", "enqueue side ignored", 64'(q_empty[3]), 64'(1));
    do_deq(3, 0);

    // R5/R10: fill to capacity twice, refuse extra, drain
    for (int round = 0; round < 2; round++) begin
      for (int i = 0; i < CAP; i++) do_enq(i % NQ, rnd_data());
      chk(round == 0 ? "R5" : "R10", "full at capacity", 64'(full), 64'(1));
      do_enq(5, 36'hDEAD);
      do_enq(1, 36'hBEEF);
      for (int q = 0; q < NQ; q++) while (rc[q] > 0) do_deq(q, 0);
      chk("R10", "all empty after drain", 64'(q_empty), 64'({NQ{1'b1}}));
    end

    // R2/R9/R10: random interleaved traffic, filling then draining
    for (int ph = 0; ph < 2; ph++) begin
      for (int i = 0; i < 2000; i++) begin
        int r = $urandom_range(99);
        int q = $urandom_range(NQ);
        if (r < (ph == 0 ? 60 : 35)) do_enq(q, rnd_data());
        else do_deq(q, r < 40);
      end
    end

    // R1: second reset discards contents
    do_enq(4, 36'h77);
    do_reset();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule